// File: doc/BRIEF.md
# Reflected Gray Code Successor

This block takes one word of a reflected Gray code and returns the word that follows it in the sequence. It is purely combinational: it decodes the Gray word to its binary rank, adds one to that rank modulo 2^WIDTH, and encodes the new rank back to Gray. It does not look the successor up in a table, so the same source serves any width. The last code word, a single one in the top position, is followed by the all-zero word.

The word width is a parameter with 4 as the default. A second parameter chooses how the Gray-to-binary decode is built. One option is a serial XOR chain running from the top bit down. The other is a logarithmic-depth suffix-XOR tree. Both options give the same outputs. The block is meant to be placed in front of a register by a surrounding counter, or to be used wherever a Gray pointer has to be advanced.

Top module: `gray_next_code`

## Requirements
- R1: With WIDTH=4, every input word produces the next entry of the cyclic sequence 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1101, 1111, 1110, 1010, 1011, 1001, 1000. Bit 3 is the most significant bit.
- R2: The last code word wraps to the first. With WIDTH=4, input 1000 gives 0000. The binary rank that is all ones rolls over to zero.
- R3: For every input, the output differs from the input in exactly one bit position.
- R4: For any WIDTH, an input equal to k XOR (k>>1) gives an output equal to m XOR (m>>1), where m = (k+1) mod 2^WIDTH. This is checked at WIDTH=6 over all 64 inputs.
- R5: The chain decode (G2B_FORM = XOR_CHAIN) and the tree decode (G2B_FORM = XOR_TREE, the default) give identical outputs for every input.
- R6: The all-zero input gives a word with only bit 0 set.
- R7: The output depends only on the current input, with no clock and no stored state. It follows an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gray_in | input | WIDTH | Current reflected Gray code word |
| gray_out | output | WIDTH | Successor Gray code word |

## Verification
Every 4-bit input is applied and compared with the listed sequence. This catches a wrong decode bit or a wrong encode bit at the exact rank where it first shows. The wrap input 1000 and the zero input are also applied on their own, because they separate a correct modulo increment from one that saturates or carries out. The full 6-bit code space is walked as well, and so is a 4-bit instance that uses the chain decode. This tells a fault in the width-generic tree stages apart from a fault in the 4-bit case. Every step is also checked for a single changed bit, and inputs are changed between clock edges to show that no state is stored.

// File: rtl/gray_pkg.sv
package gray_pkg;
  typedef enum logic {
    XOR_CHAIN = 1'b0,
    XOR_TREE  = 1'b1
  } g2b_form_e;
endpackage

// File: rtl/gray_decode.sv
module gray_decode
  import gray_pkg::*;
#(
  parameter int        WIDTH    = 4,
  parameter g2b_form_e G2B_FORM = XOR_TREE
) (
  input  logic [WIDTH-1:0] gray_i,
  output logic [WIDTH-1:0] bin_o
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;

  generate
    if (G2B_FORM == XOR_CHAIN) begin : g_chain
      // each binary bit folds in the already decoded bit above it
      always_comb begin
        bin_o[WIDTH-1] = gray_i[WIDTH-1];
        for (int i = WIDTH-2; i >= 0; i--) begin
          bin_o[i] = gray_i[i] ^ bin_o[i+1];
        end
      end
    end else begin : g_tree
      // suffix XOR by doubling spans: after stage s each bit covers 2^(s+1) bits
      logic [LEVELS:0][WIDTH-1:0] stage;
      assign stage[0] = gray_i;
      for (genvar s = 0; s < LEVELS; s++) begin : g_lvl
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
          if (i + (1 << s) < WIDTH) begin : g_mix
            assign stage[s+1][i] = stage[s][i] ^ stage[s][i + (1 << s)];
          end else begin : g_pass
            assign stage[s+1][i] = stage[s][i];
          end
        end
      end
      assign bin_o = stage[LEVELS];
    end
  endgenerate

  // R4: re-encoding the decoded rank must give back the input word
  always_comb begin
    a_r4_decode_roundtrip : assert ((bin_o ^ (bin_o >> 1)) == gray_i)
      else $error("decode of %b does not re-encode", gray_i);
  end
endmodule

// File: rtl/rank_step.sv
module rank_step #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] rank_i,
  output logic [WIDTH-1:0] rank_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  assign rank_o = rank_i + ONE;

  // R2: the top rank wraps to zero
  always_comb begin
    if (&rank_i) begin
      a_r2_rank_wrap : assert (rank_o == '0)
        else $error("rank wrap gave %b", rank_o);
    end
  end

  // R4: the rank grows by exactly one, so stepping back returns the input
  always_comb begin
    a_r4_rank_plus_one : assert ((rank_o - ONE) == rank_i)
      else $error("rank step %b -> %b", rank_i, rank_o);
  end
endmodule

// File: rtl/gray_encode.sv
module gray_encode #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] bin_i,
  output logic [WIDTH-1:0] gray_o
);
  generate
    for (genvar i = 0; i < WIDTH-1; i++) begin : g_pair
      assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
    end
  endgenerate
  assign gray_o[WIDTH-1] = bin_i[WIDTH-1];
endmodule

// File: rtl/gray_next_code.sv
module gray_next_code
  import gray_pkg::*;
#(
  parameter int        WIDTH    = 4,
  parameter g2b_form_e G2B_FORM = XOR_TREE
) (
  input  logic [WIDTH-1:0] gray_in,
  output logic [WIDTH-1:0] gray_out
);
  logic [WIDTH-1:0] rank_now;
  logic [WIDTH-1:0] rank_next;

  gray_decode #(.WIDTH(WIDTH), .G2B_FORM(G2B_FORM)) u_decode (
    .gray_i (gray_in),
    .bin_o  (rank_now)
  );

  rank_step #(.WIDTH(WIDTH)) u_step (
    .rank_i (rank_now),
    .rank_o (rank_next)
  );

  gray_encode #(.WIDTH(WIDTH)) u_encode (
    .bin_i  (rank_next),
    .gray_o (gray_out)
  );

  // R3: successor differs from its input in exactly one bit
  always_comb begin
    a_r3_one_bit_change : assert ($countones(gray_in ^ gray_out) == 1)
      else $error("step %b -> %b flips several bits", gray_in, gray_out);
  end

  // R6: the all-zero word advances to bit 0 alone
  always_comb begin
    if (gray_in == '0) begin
      a_r6_zero_start : assert (gray_out == {{(WIDTH-1){1'b0}}, 1'b1})
        else $error("zero input gave %b", gray_out);
    end
  end
endmodule

// File: tb/gray_next_code_bench.sv
`timescale 1ns/1ps
module gray_next_code_bench;
  import gray_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  logic [3:0] g4_in;
  logic [3:0] g4_out;
  logic [3:0] g4c_out;
  logic [5:0] g6_in;
  logic [5:0] g6_out;

  gray_next_code #(.WIDTH(4), .G2B_FORM(XOR_TREE)) u_gray_next_code (
    .gray_in (g4_in), .gray_out (g4_out));
  gray_next_code #(.WIDTH(4), .G2B_FORM(XOR_CHAIN)) u_gray_next_code_chain (
    .gray_in (g4_in), .gray_out (g4c_out));
  gray_next_code #(.WIDTH(6), .G2B_FORM(XOR_TREE)) u_gray_next_code_w6 (
    .gray_in (g6_in), .gray_out (g6_out));

  // R1 sequence, written out in order
  logic [3:0] seq4 [16];
  initial begin
    seq4[0]  = 4'b0000; seq4[1]  = 4'b0001; seq4[2]  = 4'b0011; seq4[3]  = 4'b0010;
    seq4[4]  = 4'b0110; seq4[5]  = 4'b0111; seq4[6]  = 4'b0101; seq4[7]  = 4'b0100;
    seq4[8]  = 4'b1100; seq4[9]  = 4'b1101; seq4[10] = 4'b1111; seq4[11] = 4'b1110;
    seq4[12] = 4'b1010; seq4[13] = 4'b1011; seq4[14] = 4'b1001; seq4[15] = 4'b1000;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive4(input logic [3:0] v);
    @(negedge clk);
    g4_in = v;
    #1;
  endtask

  task automatic t_reset_state();   // R6
    check("R6", {4'b0, g4_out}, 8'b0000_0001);
    check("R6", {4'b0, g4c_out}, 8'b0000_0001);
    check("R6", {2'b0, g6_out}, 8'b0000_0001);
  endtask

  task automatic t_full_sequence(); // R1 and R3
    for (int k = 0; k < 16; k++) begin
      drive4(seq4[k]);
      check("R1", {4'b0, g4_out}, {4'b0, seq4[(k+1) % 16]});
      check("R3", 8'($countones(g4_in ^ g4_out)), 8'd1);
    end
  endtask

  task automatic t_wrap();          // R2
    drive4(4'b1000);
    check("R2", {4'b0, g4_out}, 8'b0000_0000);
    check("R2", {4'b0, g4c_out}, 8'b0000_0000);
  endtask

  task automatic t_chain_vs_tree(); // R5
    for (int k = 0; k < 16; k++) begin
      drive4(4'(k));
      check("R5", {4'b0, g4c_out}, {4'b0, g4_out});
    end
  endtask

  task automatic t_wide();          // R4
    for (int k = 0; k < 64; k++) begin
      logic [5:0] kk;
      logic [5:0] mm;
      kk = 6'(k);
      mm = 6'((k + 1) % 64);
      @(negedge clk);
      g6_in = kk ^ (kk >> 1);
      #1;
      check("R4", {2'b0, g6_out}, {2'b0, mm ^ (mm >> 1)});
      check("R3", 8'($countones(g6_in ^ g6_out)), 8'd1);
    end
  endtask

  task automatic t_combinational(); // R7
    @(posedge clk);
    #2;
    g4_in = 4'b0110;
    #1;
    check("R7", {4'b0, g4_out}, 8'b0000_0111);
    g4_in = 4'b1011;
    #1;
    check("R7", {4'b0, g4_out}, 8'b0000_1001);
  endtask

  initial begin
    g4_in = '0;
    g6_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_full_sequence();
    t_wrap();
    t_chain_vs_tree();
    t_wide();
    t_combinational();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule